// File: doc/BRIEF.md
# Interrupt Entry and Priority Sequencer

This block decides when a small 8-bit CPU core leaves its program to service an interrupt, and which source it serves. It watches a vector of already-latched maskable requests and a software trap strobe from the instruction decoder. It acts only at an instruction boundary. When it accepts an entry, it emits a one-cycle take pulse with the chosen source index. It then streams a five-byte context save toward the stack unit and finishes by presenting the vector address for the program counter load.

A single global mask bit lives here. It is set out of reset and again by hardware on every entry, so a routine that is running can never be pre-empted. It is cleared by a return-from-interrupt strobe, or loaded by a software write to the condition-code mask. The trap is taken whatever the mask holds. A separate combinational wake output tells the power controller that a request should end a low-power state. WAIT ends on any request. HALT ends only on the sources that a parameter flags as HALT-capable.

The context save is a valid/ready stream. While `push_valid_o` is high, the command in `push_sel_o` stays fixed until a cycle in which `push_ready_i` is also high. A valid command is never withdrawn. With the ready input held high, the five transfers use five back-to-back cycles. The requesting latches sit outside this block; they clear their flag when `take_o` names them.

Top module: `irq_sequencer`

## Requirements
- R1: A maskable request is accepted only while `mask_o` is 0. A request that is present while the mask is 1 produces no take, and it is accepted at the first boundary after the mask returns to 0.
- R2: After reset, `mask_o` is 1 and `take_o`, `push_valid_o` and `vec_load_o` are 0.
- R3: An entry happens only in a cycle where `insn_end_i` is 1 and no entry sequence is in progress. `take_o` is high for exactly that one cycle.
- R4: In the cycle after `take_o`, `mask_o` reads 1.
- R5: When several sources compete, the trap wins and is reported on `take_src_o` as index NUM_SRC (8 by default). Otherwise the lowest-numbered active request wins, and its index is reported.
- R6: A trap strobe (`trap_i`) causes an entry at the boundary whatever the value of `mask_o`.
- R7: Starting the cycle after `take_o`, five push commands are issued in the order PCL=0, PCH=1, X=2, A=3, CC=4 on `push_sel_o`. Each advances only on a cycle with `push_ready_i` high. Under back-pressure, valid and the code are held.
- R8: In the cycle after the CC push is accepted, `vec_load_o` is 1 for one cycle and `vec_addr_o` equals VEC_BASE + VEC_STEP × source index (0xFFE0 + 2·index by default; 0xFFF0 for the trap).
- R9: A return strobe (`iret_i`) clears `mask_o` in the following cycle. A write (`mask_wr_i`) loads `mask_d_i` into `mask_o` in the following cycle. An entry in the same cycle takes precedence over both.
- R10: `pwr_mode_i` encodes RUN=0, WAIT=1, HALT=2. `wake_o` is 0 in RUN. In WAIT it is 1 when any request is active. In HALT it is 1 only when a request is active in HALT_WAKE_MASK (0x0F by default).
- R11: While a sequence is in progress, `insn_end_i` and the requests produce no further `take_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | NUM_SRC | Latched maskable requests, bit i is source i |
| trap_i | input | 1 | Software trap strobe from the decoder |
| insn_end_i | input | 1 | Current instruction completes this cycle |
| iret_i | input | 1 | Return-from-interrupt strobe |
| mask_wr_i | input | 1 | Software write of the global mask |
| mask_d_i | input | 1 | Value for the mask write |
| pwr_mode_i | input | 2 | Power state: 0 RUN, 1 WAIT, 2 HALT |
| push_ready_i | input | 1 | Stack unit accepts the current push |
| take_o | output | 1 | One-cycle interrupt entry pulse |
| take_src_o | output | SRC_W | Index of the source taken (NUM_SRC = trap) |
| push_valid_o | output | 1 | Push command valid |
| push_sel_o | output | 3 | Register to push: 0 PCL, 1 PCH, 2 X, 3 A, 4 CC |
| vec_load_o | output | 1 | Load program counter from `vec_addr_o` |
| vec_addr_o | output | VEC_W | Vector address of the source taken |
| mask_o | output | 1 | Global interrupt mask |
| wake_o | output | 1 | Request to leave the low-power state |

## Verification
Several properties are checked on every cycle. A maskable take only ever appears with the mask clear. The mask reads set right after any take. The push stream holds under stall and advances by one code per accepted transfer. The vector load follows the CC push. Priority is checked on every take, and an IRET clears the mask. The bench scenarios cover what a single-cycle property cannot express. These are: a masked request that waits and is then served once the mask is cleared, the exact vector addresses, the whole push order under random stalls, and the HALT-capable filtering of the wake output across modes.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PUSH = 2'd1,
    SEQ_VEC  = 2'd2
  } seq_state_t;

  typedef enum logic [2:0] {
    CTX_PCL = 3'd0,
    CTX_PCH = 3'd1,
    CTX_X   = 3'd2,
    CTX_A   = 3'd3,
    CTX_CC  = 3'd4
  } ctx_reg_t;

  localparam int unsigned CTX_COUNT = 5;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_WAIT = 2'd1,
    PWR_HALT = 2'd2
  } pwr_mode_t;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned SRC_W   = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               trap_i,
  output logic               any_o,
  output logic [SRC_W-1:0]   src_o
);

  localparam logic [SRC_W-1:0] TRAP_IDX = SRC_W'(NUM_SRC);

  // Lowest index has priority: a chain of "nothing below me" terms.
  logic [NUM_SRC:0] none_below;
  logic [NUM_SRC-1:0] grant;

  assign none_below[0] = 1'b1;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    assign grant[g]          = req_i[g] & none_below[g];
    assign none_below[g + 1] = none_below[g] & ~req_i[g];
  end

  always_comb begin
    src_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) src_o = SRC_W'(i);
    end
    if (trap_i) src_o = TRAP_IDX;
  end

  assign any_o = trap_i | ~none_below[NUM_SRC];

endmodule

// File: rtl/irq_wake_logic.sv
module irq_wake_logic
  import irq_seq_pkg::*;
#(
  parameter int unsigned          NUM_SRC        = 8,
  parameter logic [NUM_SRC-1:0]   HALT_WAKE_MASK = 8'h0F
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [1:0]         pwr_mode_i,
  output logic               wake_o
);

  logic [NUM_SRC-1:0] halt_ok;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_halt
    if (HALT_WAKE_MASK[g]) begin : g_cap
      assign halt_ok[g] = req_i[g];
    end else begin : g_nocap
      assign halt_ok[g] = 1'b0;
    end
  end

  always_comb begin
    unique case (pwr_mode_i)
      PWR_WAIT: wake_o = |req_i;
      PWR_HALT: wake_o = |halt_ok;
      default:  wake_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_seq_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 8,
  parameter int unsigned SRC_W    = $clog2(NUM_SRC + 1),
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned VEC_BASE = 'hFFE0,
  parameter int unsigned VEC_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_end_i,
  input  logic             pick_any_i,
  input  logic [SRC_W-1:0] pick_src_i,
  input  logic             iret_i,
  input  logic             mask_wr_i,
  input  logic             mask_d_i,
  input  logic             push_ready_i,
  output logic             take_o,
  output logic             mask_o,
  output logic             push_valid_o,
  output logic [2:0]       push_sel_o,
  output logic             vec_load_o,
  output logic [VEC_W-1:0] vec_addr_o
);

  localparam logic [VEC_W-1:0] BASE_V = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] STEP_V = VEC_W'(VEC_STEP);
  localparam logic [2:0]       LAST_CTX = 3'(CTX_COUNT - 1);

  seq_state_t       state_q;
  logic [2:0]       ctx_q;
  logic [SRC_W-1:0] src_q;

  assign take_o       = (state_q == SEQ_IDLE) && insn_end_i && pick_any_i;
  assign push_valid_o = (state_q == SEQ_PUSH);
  assign push_sel_o   = ctx_q;
  assign vec_load_o   = (state_q == SEQ_VEC);
  assign vec_addr_o   = BASE_V + STEP_V * VEC_W'(src_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      ctx_q   <= 3'(CTX_PCL);
      src_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (take_o) begin
            state_q <= SEQ_PUSH;
            ctx_q   <= 3'(CTX_PCL);
            src_q   <= pick_src_i;
          end
        end
        SEQ_PUSH: begin
          if (push_ready_i) begin
            if (ctx_q == LAST_CTX) state_q <= SEQ_VEC;
            else                   ctx_q   <= ctx_q + 3'd1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // Mask: entry wins, then return, then software write.
  always_ff @(posedge clk) begin
    if (!rst_n)         mask_o <= 1'b1;
    else if (take_o)    mask_o <= 1'b1;
    else if (iret_i)    mask_o <= 1'b0;
    else if (mask_wr_i) mask_o <= mask_d_i;
  end

  AST_MASK_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> mask_o); // R4

  AST_PUSH_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid_o && !push_ready_i) |=> (push_valid_o && $stable(push_sel_o))); // R7

  AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid_o && push_ready_i && push_sel_o != LAST_CTX)
      |=> (push_valid_o && push_sel_o == $past(push_sel_o) + 3'd1)); // R7

  AST_VEC_AFTER_CC: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid_o && push_ready_i && push_sel_o == LAST_CTX) |=> vec_load_o); // R8

  AST_IRET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (iret_i && !take_o) |=> !mask_o); // R9

  AST_NO_TAKE_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid_o || vec_load_o) |-> !take_o); // R11

endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_seq_pkg::*;
#(
  parameter int unsigned        NUM_SRC        = 8,
  parameter int unsigned        SRC_W          = $clog2(NUM_SRC + 1),
  parameter int unsigned        VEC_W          = 16,
  parameter int unsigned        VEC_BASE       = 'hFFE0,
  parameter int unsigned        VEC_STEP       = 2,
  parameter logic [NUM_SRC-1:0] HALT_WAKE_MASK = 8'h0F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req_i,
  input  logic               trap_i,
  input  logic               insn_end_i,
  input  logic               iret_i,
  input  logic               mask_wr_i,
  input  logic               mask_d_i,
  input  logic [1:0]         pwr_mode_i,
  input  logic               push_ready_i,
  output logic               take_o,
  output logic [SRC_W-1:0]   take_src_o,
  output logic               push_valid_o,
  output logic [2:0]         push_sel_o,
  output logic               vec_load_o,
  output logic [VEC_W-1:0]   vec_addr_o,
  output logic               mask_o,
  output logic               wake_o
);

  localparam logic [SRC_W-1:0] TRAP_IDX = SRC_W'(NUM_SRC);

  logic               trap_pend_q;
  logic               trap_any;
  logic [NUM_SRC-1:0] eligible;
  logic               pick_any;

  assign trap_any = trap_i | trap_pend_q;
  assign eligible = mask_o ? '0 : irq_req_i;

  // A trap strobe seen outside a boundary waits here until taken.
  always_ff @(posedge clk) begin
    if (!rst_n)                                trap_pend_q <= 1'b0;
    else if (take_o && take_src_o == TRAP_IDX) trap_pend_q <= 1'b0;
    else if (trap_i)                           trap_pend_q <= 1'b1;
  end

  irq_prio_pick #(
    .NUM_SRC (NUM_SRC),
    .SRC_W   (SRC_W)
  ) u_pick (
    .req_i  (eligible),
    .trap_i (trap_any),
    .any_o  (pick_any),
    .src_o  (take_src_o)
  );

  irq_entry_fsm #(
    .NUM_SRC  (NUM_SRC),
    .SRC_W    (SRC_W),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .insn_end_i   (insn_end_i),
    .pick_any_i   (pick_any),
    .pick_src_i   (take_src_o),
    .iret_i       (iret_i),
    .mask_wr_i    (mask_wr_i),
    .mask_d_i     (mask_d_i),
    .push_ready_i (push_ready_i),
    .take_o       (take_o),
    .mask_o       (mask_o),
    .push_valid_o (push_valid_o),
    .push_sel_o   (push_sel_o),
    .vec_load_o   (vec_load_o),
    .vec_addr_o   (vec_addr_o)
  );

  irq_wake_logic #(
    .NUM_SRC        (NUM_SRC),
    .HALT_WAKE_MASK (HALT_WAKE_MASK)
  ) u_wake (
    .req_i      (irq_req_i),
    .pwr_mode_i (pwr_mode_i),
    .wake_o     (wake_o)
  );

  logic [NUM_SRC-1:0] take_hot;
  assign take_hot = NUM_SRC'(1) << take_src_o;

  AST_MASKED_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && take_src_o != TRAP_IDX) |-> (!mask_o && (irq_req_i & take_hot) != '0)); // R1

  AST_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && trap_any) |-> (take_src_o == TRAP_IDX)); // R5

  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !trap_any) |-> ((irq_req_i & (take_hot - NUM_SRC'(1))) == '0)); // R5

  AST_TAKE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> insn_end_i); // R3

  AST_RUN_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode_i == PWR_RUN) |-> !wake_o); // R10

endmodule

// File: tb/irq_sequencer_tb.sv
`timescale 1ns/1ps
module irq_sequencer_tb;

  localparam int NSRC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_req = '0;
  logic       trap = 1'b0, insn_end = 1'b0, iret = 1'b0;
  logic       mask_wr = 1'b0, mask_d = 1'b0, push_ready = 1'b1;
  logic [1:0] pwr_mode = 2'd0;
  logic       take, push_valid, vec_load, mask, wake;
  logic [3:0] take_src;
  logic [2:0] push_sel;
  logic [15:0] vec_addr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .trap_i(trap),
    .insn_end_i(insn_end), .iret_i(iret), .mask_wr_i(mask_wr), .mask_d_i(mask_d),
    .pwr_mode_i(pwr_mode), .push_ready_i(push_ready), .take_o(take),
    .take_src_o(take_src), .push_valid_o(push_valid), .push_sel_o(push_sel),
    .vec_load_o(vec_load), .vec_addr_o(vec_addr), .mask_o(mask), .wake_o(wake)
  );

  function automatic int exp_pick(logic [7:0] req, logic t);
    if (t) return NSRC;
    for (int i = 0; i < NSRC; i++) if (req[i]) return i;
    return 0;
  endfunction

  function automatic logic [15:0] exp_vec(int src);
    return 16'hFFE0 + 16'(2 * src);
  endfunction

  function automatic logic exp_wake(logic [1:0] mode, logic [7:0] req);
    if (mode == 2'd1) return |req;
    if (mode == 2'd2) return |(req & 8'h0F);
    return 1'b0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Caller has set requests/trap; this raises the boundary and checks the sequence.
  task automatic run_entry(int exp_src, bit stalls);
    insn_end = 1'b1;
    #1;
    chk("R3", "take_o at boundary", take, 1);
    chk("R5", "take_src_o", take_src, exp_src);
    step();
    trap = 1'b0;
    chk("R4", "mask_o after take", mask, 1);
    for (int k = 0; k < 5; k++) begin
      bit acc;
      acc = 1'b0;
      while (!acc) begin
        push_ready = stalls ? ($urandom % 3 != 0) : 1'b1;
        insn_end = $urandom % 2;
        #1;
        chk("R7", "push_valid_o", push_valid, 1);
        chk("R7", "push_sel_o order", push_sel, k);
        chk("R11", "no take during sequence", take, 0);
        acc = push_ready;
        step();
      end
    end
    push_ready = 1'b1;
    insn_end = 1'b0;
    #1;
    chk("R8", "vec_load_o", vec_load, 1);
    chk("R8", "vec_addr_o", vec_addr, exp_vec(exp_src));
    chk("R11", "no take at vector load", take, 0);
    step();
    #1;
    chk("R8", "vec_load_o one cycle", vec_load, 0);
  endtask

  task automatic do_iret();
    step();
    iret = 1'b1;
    step();
    iret = 1'b0;
    #1;
    chk("R9", "mask_o cleared by iret", mask, 0);
  endtask

  task automatic write_mask(logic v);
    step();
    mask_wr = 1'b1;
    mask_d = v;
    step();
    mask_wr = 1'b0;
    #1;
    chk("R9", "mask_o after write", mask, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    #1;
    // R2 reset state
    chk("R2", "mask_o reset", mask, 1);
    chk("R2", "take_o reset", take, 0);
    chk("R2", "push_valid_o reset", push_valid, 0);
    chk("R2", "vec_load_o reset", vec_load, 0);

    // R1 masked request waits
    step();
    irq_req = 8'h10;
    insn_end = 1'b1;
    #1;
    chk("R1", "no take while masked", take, 0);
    step();
    insn_end = 1'b0;
    write_mask(1'b0);
    // R3 no boundary -> no take
    repeat (3) begin
      step();
      #1;
      chk("R3", "no take without boundary", take, 0);
    end
    step();
    run_entry(4, 1'b0);
    irq_req = 8'h00;
    do_iret();

    // R5 priority among requests
    step();
    irq_req = 8'h28;
    run_entry(3, 1'b1);
    irq_req = 8'h20;
    do_iret();
    step();
    irq_req = 8'h81;
    run_entry(0, 1'b0);
    irq_req = 8'h00;
    do_iret();

    // R6 trap with mask set
    write_mask(1'b1);
    step();
    irq_req = 8'h02;
    trap = 1'b1;
    run_entry(NSRC, 1'b1);
    // R5 trap outranks request with mask clear
    do_iret();
    step();
    trap = 1'b1;
    run_entry(NSRC, 1'b0);
    irq_req = 8'h00;
    do_iret();

    // R9 entry beats iret in same cycle
    step();
    irq_req = 8'h04;
    iret = 1'b1;
    insn_end = 1'b1;
    #1;
    chk("R3", "take with iret", take, 1);
    step();
    iret = 1'b0;
    insn_end = 1'b0;
    #1;
    chk("R9", "entry wins over iret", mask, 1);
    repeat (8) step();
    irq_req = 8'h00;
    do_iret();

    // R10 wake rules
    begin
      logic [1:0] modes [5] = '{2'd1, 2'd2, 2'd2, 2'd0, 2'd1};
      logic [7:0] reqs  [5] = '{8'h80, 8'h80, 8'h02, 8'hFF, 8'h00};
      for (int i = 0; i < 5; i++) begin
        step();
        pwr_mode = modes[i];
        irq_req = reqs[i];
        #1;
        chk("R10", "wake_o directed", wake, exp_wake(modes[i], reqs[i]));
      end
    end

    // random mix
    for (int it = 0; it < 80; it++) begin
      logic [7:0] r;
      logic t, m;
      r = 8'($urandom);
      t = ($urandom % 5 == 0);
      m = $urandom % 2;
      write_mask(m);
      step();
      pwr_mode = 2'($urandom % 3);
      irq_req = r;
      trap = t;
      #1;
      chk("R10", "wake_o random", wake, exp_wake(pwr_mode, r));
      pwr_mode = 2'd0;
      if (t || (!m && r != 0)) begin
        run_entry(exp_pick(m ? 8'h00 : r, t), 1'b1);
        irq_req = 8'h00;
        do_iret();
      end else begin
        insn_end = 1'b1;
        #1;
        chk("R1", "no take masked random", take, 0);
        step();
        insn_end = 1'b0;
        irq_req = 8'h00;
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule